// File: doc/BRIEF.md
# Double-Buffered Serial Transmit Controller

This block runs the transmit side of a byte-oriented serial port. Software writes a control byte and data bytes. A data byte written while the line is idle is sent to the serializer at once. A byte written while a frame is still on the line is parked in a holding register until that frame finishes. Two status flags report progress. The empty flag means the holding register can take another byte. The end flag means nothing is left to shift.

The serializer is not part of this block. It receives a one-cycle start strobe with the byte to send, and its bit timer returns a frame-done strobe when the last bit has left. The block drives two interrupt outputs. The first is a one-cycle pulse each time the holding register frees up. The second is a level that stays high while the line is idle, provided its enable bit is set.

Top module: `tx_dbuf_ctrl`

## Requirements
- R1: After reset, the status byte reads 0x84 (bit 7 is the empty flag, bit 2 is the end flag, all other bits 0). The data register reads all ones, the control register reads 0x00, and both interrupts and the start strobe are low.
- R2: A control write stores all 8 bits. The bits that matter here are bit 2 (end-interrupt enable), bit 5 (transmit enable) and bit 7 (data-interrupt enable). When bit 5 is set, the write forces both status flags to 1, and the data interrupt pulses if bit 7 of the written value is set.
- R3: A data write while the end flag is 1 produces the start strobe on the next cycle, carrying the written byte. The end flag clears and the empty flag stays 1.
- R4: A data write while the end flag is 0 stores the byte in the data register and clears the empty flag. No start strobe is produced.
- R5: A frame-done strobe while the empty flag is 0 starts the held byte on the next cycle. The empty flag returns to 1 and the end flag stays 0.
- R6: A frame-done strobe while the empty flag is 1 sets the end flag. It raises the end interrupt level if control bit 2 is set.
- R7: Every byte start drops the end interrupt. It also pulses the data interrupt for one cycle if control bit 7 is set, and does not pulse it if bit 7 is clear.
- R8: A control write with bit 2 clear drops the end interrupt on the next cycle.
- R9: A data write in the same cycle as a frame-done strobe acts as if it arrived just after the frame-done. A held byte is started, and the new byte becomes the held byte. When nothing was held, the new byte is started directly.
- R10: The data interrupt is a pulse one cycle wide. It is low in the cycle that follows a cycle with no triggering event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 8 | Control write value |
| dataWrEn | input | 1 | Data register write strobe |
| dataWrData | input | DATA_W | Data write value |
| frameDone | input | 1 | End-of-frame strobe from the bit timer |
| ctrlReg | output | 8 | Control register contents |
| txDataReg | output | DATA_W | Data (holding) register contents |
| statusReg | output | 8 | Status byte: bit 7 empty, bit 2 end |
| startStrobe | output | 1 | One-cycle start toward the serializer |
| shiftByte | output | DATA_W | Byte handed to the serializer |
| txDataIrq | output | 1 | Holding-register-free interrupt pulse |
| txEndIrq | output | 1 | Transmit-end interrupt level |

## Verification
The bench builds the block with its default data width of 8. At that width, the reset pattern of all ones, the 0x84 status byte and every byte value of the direct-start, hold and chain paths can be compared against constants. The directed sequences cover these paths:
- direct start from idle;
- holding a byte behind a busy frame;
- chaining the held byte at frame-done;
- falling back to idle with the end interrupt enabled and disabled;
- the collision of a frame-done strobe with a data write, both with a byte held and with none.

// File: rtl/tx_dbuf_pkg.sv
package tx_dbuf_pkg;
  localparam int CTRL_W    = 8;
  localparam int CTRL_TEIE = 2;
  localparam int CTRL_TE   = 5;
  localparam int CTRL_TIE  = 7;
  localparam int STAT_END  = 2;
  localparam int STAT_EMPTY = 7;

  typedef struct packed {
    logic loadCtrl;
    logic loadHold;
    logic startHeld;
    logic startNew;
  } txStrobes_t;
endpackage

// File: rtl/tx_dbuf_fsm.sv
module tx_dbuf_fsm
  import tx_dbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              dataWrEn,
  input  logic              frameDone,
  input  logic [CTRL_W-1:0] ctrlReg,
  output txStrobes_t        strobes,
  output logic              emptyQ,
  output logic              endQ,
  output logic              dataIrqQ,
  output logic              endIrqQ
);
  logic [CTRL_W-1:0] effCtrl;
  logic emptyD, endD, endIrqD, pulseD;

  always_comb begin
    effCtrl = ctrlWrEn ? ctrlWrData : ctrlReg;
    emptyD  = emptyQ;
    endD    = endQ;
    endIrqD = endIrqQ;
    pulseD  = 1'b0;
    strobes = '0;
    strobes.loadCtrl = ctrlWrEn;
    strobes.loadHold = dataWrEn;
    // control write comes first
    if (ctrlWrEn) begin
      if (effCtrl[CTRL_TE]) begin
        emptyD = 1'b1;
        endD   = 1'b1;
        if (effCtrl[CTRL_TIE]) pulseD = 1'b1;
      end
      if (!effCtrl[CTRL_TEIE]) endIrqD = 1'b0;
    end
    // then the end of the current frame
    if (frameDone) begin
      if (!emptyD) begin
        strobes.startHeld = 1'b1;
        endD    = 1'b0;
        emptyD  = 1'b1;
        endIrqD = 1'b0;
        if (effCtrl[CTRL_TIE]) pulseD = 1'b1;
      end else begin
        endD = 1'b1;
        if (effCtrl[CTRL_TEIE]) endIrqD = 1'b1;
      end
    end
    // a data write is seen last
    if (dataWrEn) begin
      if (endD) begin
        strobes.startNew = 1'b1;
        endD    = 1'b0;
        emptyD  = 1'b1;
        endIrqD = 1'b0;
        if (effCtrl[CTRL_TIE]) pulseD = 1'b1;
      end else begin
        emptyD = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      emptyQ   <= 1'b1;
      endQ     <= 1'b1;
      dataIrqQ <= 1'b0;
      endIrqQ  <= 1'b0;
    end else begin
      emptyQ   <= emptyD;
      endQ     <= endD;
      dataIrqQ <= pulseD;
      endIrqQ  <= endIrqD;
    end
  end

  // R6: the end interrupt is only ever high while the end flag is high
  p_end_irq_needs_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    endIrqQ |-> endQ);
  // R2: a data interrupt pulse always matches an enabled interrupt bit
  p_tdi_needs_tie_r2: assert property (@(posedge clk) disable iff (!rstN)
    dataIrqQ |-> ctrlReg[CTRL_TIE]);
  // R8: clearing the enable bit drops the end interrupt
  p_teie_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrEn && !ctrlWrData[CTRL_TEIE] |=> !endIrqQ);
endmodule

// File: rtl/tx_dbuf_dp.sv
module tx_dbuf_dp
  import tx_dbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        strobes,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic [DATA_W-1:0] dataWrData,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic [DATA_W-1:0] holdReg,
  output logic              startStrobe,
  output logic [DATA_W-1:0] shiftByte
);
  localparam logic [DATA_W-1:0] HOLD_RST = {DATA_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg     <= '0;
      holdReg     <= HOLD_RST;
      startStrobe <= 1'b0;
      shiftByte   <= '0;
    end else begin
      if (strobes.loadCtrl) ctrlReg <= ctrlWrData;
      if (strobes.loadHold) holdReg <= dataWrData;
      startStrobe <= strobes.startHeld | strobes.startNew;
      if (strobes.startHeld)     shiftByte <= holdReg;
      else if (strobes.startNew) shiftByte <= dataWrData;
    end
  end

  // R9: a cycle never starts both the held byte and a fresh byte
  p_one_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.startHeld && strobes.startNew));
endmodule

// File: rtl/tx_dbuf_ctrl.sv
module tx_dbuf_ctrl
  import tx_dbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [7:0]        ctrlWrData,
  input  logic              dataWrEn,
  input  logic [DATA_W-1:0] dataWrData,
  input  logic              frameDone,
  output logic [7:0]        ctrlReg,
  output logic [DATA_W-1:0] txDataReg,
  output logic [7:0]        statusReg,
  output logic              startStrobe,
  output logic [DATA_W-1:0] shiftByte,
  output logic              txDataIrq,
  output logic              txEndIrq
);
  txStrobes_t strobes;
  logic emptyQ, endQ;

  tx_dbuf_fsm u_fsm (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .dataWrEn(dataWrEn), .frameDone(frameDone), .ctrlReg(ctrlReg),
    .strobes(strobes), .emptyQ(emptyQ), .endQ(endQ),
    .dataIrqQ(txDataIrq), .endIrqQ(txEndIrq)
  );

  tx_dbuf_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ctrlWrData(ctrlWrData),
    .dataWrData(dataWrData), .ctrlReg(ctrlReg), .holdReg(txDataReg),
    .startStrobe(startStrobe), .shiftByte(shiftByte)
  );

  always_comb begin
    statusReg = '0;
    statusReg[STAT_EMPTY] = emptyQ;
    statusReg[STAT_END]   = endQ;
  end

  // R3: writing while idle starts that very byte next cycle
  p_direct_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    dataWrEn && statusReg[STAT_END] && !frameDone
      |=> startStrobe && (shiftByte == $past(dataWrData)));
  // R4: writing while busy holds the byte without a start
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    dataWrEn && !statusReg[STAT_END] && !frameDone && !ctrlWrEn
      |=> !startStrobe && !statusReg[STAT_EMPTY]);
endmodule

// File: tb/tb_tx_dbuf_ctrl.sv
module tb_tx_dbuf_ctrl;
  localparam int DATA_W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWrEn = 1'b0;
  logic [7:0] ctrlWrData = '0;
  logic dataWrEn = 1'b0;
  logic [DATA_W-1:0] dataWrData = '0;
  logic frameDone = 1'b0;
  logic [7:0] ctrlReg;
  logic [DATA_W-1:0] txDataReg;
  logic [7:0] statusReg;
  logic startStrobe;
  logic [DATA_W-1:0] shiftByte;
  logic txDataIrq, txEndIrq;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_dbuf_ctrl #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .dataWrEn(dataWrEn), .dataWrData(dataWrData), .frameDone(frameDone),
    .ctrlReg(ctrlReg), .txDataReg(txDataReg), .statusReg(statusReg),
    .startStrobe(startStrobe), .shiftByte(shiftByte),
    .txDataIrq(txDataIrq), .txEndIrq(txEndIrq)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // one clock with the given inputs; results are sampled just after the edge
  task automatic cyc(input logic cw, input logic [7:0] cd, input logic dw,
                     input logic [DATA_W-1:0] dd, input logic fd);
    @(negedge clk);
    ctrlWrEn = cw; ctrlWrData = cd; dataWrEn = dw; dataWrData = dd; frameDone = fd;
    @(posedge clk);
    #1;
    @(negedge clk);
    ctrlWrEn = 1'b0; dataWrEn = 1'b0; frameDone = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", "status", statusReg, 32'h84);
    check("R1", "data reg", txDataReg, 32'hFF);
    check("R1", "ctrl reg", ctrlReg, 32'h00);
    check("R1", "irqs+start", {txDataIrq, txEndIrq, startStrobe}, 32'h0);
  endtask

  task automatic t_ctrl_enable;
    cyc(1'b1, 8'hA4, 1'b0, '0, 1'b0);
    check("R2", "ctrl reg", ctrlReg, 32'hA4);
    check("R2", "status", statusReg, 32'h84);
    check("R2", "data irq pulse", txDataIrq, 32'h1);
    cyc(1'b0, '0, 1'b0, '0, 1'b0);
    check("R10", "data irq back low", txDataIrq, 32'h0);
  endtask

  task automatic t_direct;
    cyc(1'b0, '0, 1'b1, 8'h5A, 1'b0);
    check("R3", "start", startStrobe, 32'h1);
    check("R3", "shift byte", shiftByte, 32'h5A);
    check("R3", "status", statusReg, 32'h80);
    check("R7", "data irq", txDataIrq, 32'h1);
  endtask

  task automatic t_hold;
    cyc(1'b0, '0, 1'b1, 8'h3C, 1'b0);
    check("R4", "no start", startStrobe, 32'h0);
    check("R4", "status", statusReg, 32'h00);
    check("R4", "data reg", txDataReg, 32'h3C);
  endtask

  task automatic t_chain;
    cyc(1'b0, '0, 1'b0, '0, 1'b1);
    check("R5", "start", startStrobe, 32'h1);
    check("R5", "shift byte", shiftByte, 32'h3C);
    check("R5", "status", statusReg, 32'h80);
  endtask

  task automatic t_end;
    cyc(1'b0, '0, 1'b0, '0, 1'b1);
    check("R6", "status", statusReg, 32'h84);
    check("R6", "end irq", txEndIrq, 32'h1);
    check("R6", "no start", startStrobe, 32'h0);
  endtask

  task automatic t_teie_off;
    cyc(1'b1, 8'h80, 1'b0, '0, 1'b0);
    check("R8", "end irq dropped", txEndIrq, 32'h0);
    check("R8", "status kept", statusReg, 32'h84);
    // disabled end interrupt stays low at frame end
    cyc(1'b0, '0, 1'b1, 8'h11, 1'b0);
    cyc(1'b0, '0, 1'b0, '0, 1'b1);
    check("R6", "end irq disabled", txEndIrq, 32'h0);
    check("R6", "end flag", statusReg, 32'h84);
  endtask

  task automatic t_start_drops_irq;
    cyc(1'b1, 8'hA4, 1'b0, '0, 1'b0);
    cyc(1'b0, '0, 1'b1, 8'h21, 1'b0);
    cyc(1'b0, '0, 1'b0, '0, 1'b1);
    check("R7", "end irq up", txEndIrq, 32'h1);
    cyc(1'b0, '0, 1'b1, 8'h22, 1'b0);
    check("R7", "end irq dropped by start", txEndIrq, 32'h0);
    check("R7", "start", startStrobe, 32'h1);
  endtask

  task automatic t_collide;
    // a start is in flight here: end=0, empty=1
    cyc(1'b0, '0, 1'b1, 8'h33, 1'b0);
    check("R9", "held", statusReg, 32'h00);
    cyc(1'b0, '0, 1'b1, 8'h44, 1'b1);
    check("R9", "start held", startStrobe, 32'h1);
    check("R9", "shift old held", shiftByte, 32'h33);
    check("R9", "new byte held", txDataReg, 32'h44);
    check("R9", "status", statusReg, 32'h00);
    cyc(1'b0, '0, 1'b0, '0, 1'b1);
    check("R9", "chained", shiftByte, 32'h44);
    check("R9", "status", statusReg, 32'h80);
    cyc(1'b0, '0, 1'b1, 8'h55, 1'b1);
    check("R9", "direct start", startStrobe, 32'h1);
    check("R9", "direct byte", shiftByte, 32'h55);
    check("R9", "status", statusReg, 32'h80);
    check("R9", "end irq", txEndIrq, 32'h0);
  endtask

  task automatic t_no_tie;
    cyc(1'b0, '0, 1'b0, '0, 1'b1);
    cyc(1'b1, 8'h24, 1'b0, '0, 1'b0);
    check("R2", "no pulse without bit 7", txDataIrq, 32'h0);
    cyc(1'b0, '0, 1'b1, 8'h66, 1'b0);
    check("R7", "start without pulse", {startStrobe, txDataIrq}, 32'h2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    #1;
    t_reset();
    t_ctrl_enable();
    t_direct();
    t_hold();
    t_chain();
    t_end();
    t_teie_off();
    t_start_drops_irq();
    t_collide();
    t_no_tie();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule